// File: doc/BRIEF.md
# PWM Output Crossover and Gating Unit

This block sits between a three-phase PWM timing unit and the six gate-drive pads. For each phase pair it takes a high-side and a low-side drive signal from the timing unit and passes them to the pads through two stages. The first stage can exchange the high-side and low-side signals of a pair (crossover). The second stage can force any single pad to its inactive level. Together these stages let firmware commutate an electronically commutated or brushed DC motor without reprogramming the timing unit.

A 9-bit control word sets both stages. It is written through a single write strobe and can always be read back. A new word is held in a pending register and is copied into the working register only when the timing unit signals a PWM period start. A reconfiguration therefore never cuts a pulse in the middle of a period. The pads are registered, so they stay glitch-free.

Top module: `pwm_out_ctrl`

## Requirements
- R1: While `rst_ni` is low, both the pending and the working control words are 0, `cfg_rdata_o` reads 0 and every pad is 0. After release, the unit passes signals straight through with all pads enabled.
- R2: A write strobe stores `cfg_wdata_i` in the pending word, and `cfg_rdata_o` shows it from the following clock edge on.
- R3: A write made without a period start has no effect on the pads. They keep following the previous working word until a period start arrives.
- R4: When `period_start_i` is high in a cycle, the pending word becomes the working word. The pad values registered at that same edge already follow the new word.
- R5: The crossover bits are bit 8 for pair A, bit 7 for pair B and bit 6 for pair C. Pair index 0 is A, 1 is B and 2 is C. When a pair's crossover bit is set, the pair's high-side input drives its low-side pad and its low-side input drives its high-side pad. Other pairs are not affected.
- R6: The disable bits are bit 5 for the A high pad, bit 4 for the A low pad, bit 3 for the B high pad, bit 2 for the B low pad, bit 1 for the C high pad and bit 0 for the C low pad. Each bit forces its physical pad to 0, the inactive level, after any crossover has been applied.
- R7: Each pad is registered. Its value after clock edge k depends only on the inputs sampled at edge k and on the working word in force for that edge.
- R8: If a write and a period start fall in the same cycle, the newly written word takes effect at that period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Write strobe for the control word |
| cfg_wdata_i | input | 9 | Control word to write |
| cfg_rdata_o | output | 9 | Pending control word read back |
| period_start_i | input | 1 | One-cycle pulse at the start of each PWM period |
| pwm_hi_i | input | 3 | High-side drive from the timing unit, index 0 = A |
| pwm_lo_i | input | 3 | Low-side drive from the timing unit, index 0 = A |
| pad_hi_o | output | 3 | High-side pad drive, index 0 = A |
| pad_lo_o | output | 3 | Low-side pad drive, index 0 = A |

## Verification
Pads and readback are both due one clock edge after the cycle in which their stimulus is applied. A new configuration becomes visible in the pad values registered at the period-start edge itself, not one edge later. The driver applies inputs on the falling edge and queues each expected result tagged with the rising-edge count at which it is due. The monitor compares, on the following falling edge, only the entries whose edge count has been reached. This lets pending-versus-working behaviour, coincident writes and resets be checked without any guess about timing.

// File: rtl/pwm_oc_pkg.sv
package pwm_oc_pkg;
  // control word: [3N-1 : 2N] crossover (pair 0 at msb), [2N-1 : 0] disables (pair 0 hi at msb)
  function automatic int xover_bit(input int p, input int n);
    return 3 * n - 1 - p;
  endfunction

  function automatic int dis_hi_bit(input int p, input int n);
    return 2 * n - 1 - 2 * p;
  endfunction

  function automatic int dis_lo_bit(input int p, input int n);
    return 2 * n - 2 - 2 * p;
  endfunction
endpackage

// File: rtl/pwm_oc_cfg.sv
module pwm_oc_cfg #(
  parameter int CW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          period_start_i,
  output logic [CW-1:0] pend_o,
  output logic [CW-1:0] act_o,
  output logic [CW-1:0] act_nxt_o
);
  logic [CW-1:0] pend_q, act_q, pend_nxt;

  assign pend_nxt  = wr_i ? wdata_i : pend_q;
  // coincident write lands in the same period start
  assign act_nxt_o = period_start_i ? pend_nxt : act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_nxt;
      act_q  <= act_nxt_o;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;
endmodule

// File: rtl/pwm_oc_pair.sv
module pwm_oc_pair (
  input  logic swap_i,
  input  logic dis_hi_i,
  input  logic dis_lo_i,
  input  logic hi_i,
  input  logic lo_i,
  output logic hi_o,
  output logic lo_o
);
  logic hi_x, lo_x;

  assign hi_x = swap_i ? lo_i : hi_i;
  assign lo_x = swap_i ? hi_i : lo_i;
  // gate per physical pad, after swap
  assign hi_o = hi_x & ~dis_hi_i;
  assign lo_o = lo_x & ~dis_lo_i;
endmodule

// File: rtl/pwm_oc_pad_reg.sv
module pwm_oc_pad_reg #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hi_i,
  input  logic [N-1:0] lo_i,
  output logic [N-1:0] hi_o,
  output logic [N-1:0] lo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_o <= '0;
      lo_o <= '0;
    end else begin
      hi_o <= hi_i;
      lo_o <= lo_i;
    end
  end
endmodule

// File: rtl/pwm_out_ctrl.sv
module pwm_out_ctrl #(
  parameter int N_PAIRS = 3,
  localparam int CW = 3 * N_PAIRS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_wr_i,
  input  logic [CW-1:0]      cfg_wdata_i,
  output logic [CW-1:0]      cfg_rdata_o,
  input  logic               period_start_i,
  input  logic [N_PAIRS-1:0] pwm_hi_i,
  input  logic [N_PAIRS-1:0] pwm_lo_i,
  output logic [N_PAIRS-1:0] pad_hi_o,
  output logic [N_PAIRS-1:0] pad_lo_o
);
  import pwm_oc_pkg::*;

  logic [CW-1:0]      act_cfg, act_nxt;
  logic [N_PAIRS-1:0] hi_d, lo_d;

  pwm_oc_cfg #(.CW(CW)) cfg_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_i           (cfg_wr_i),
    .wdata_i        (cfg_wdata_i),
    .period_start_i (period_start_i),
    .pend_o         (cfg_rdata_o),
    .act_o          (act_cfg),
    .act_nxt_o      (act_nxt)
  );

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    pwm_oc_pair pair_i (
      .swap_i   (act_nxt[xover_bit(p, N_PAIRS)]),
      .dis_hi_i (act_nxt[dis_hi_bit(p, N_PAIRS)]),
      .dis_lo_i (act_nxt[dis_lo_bit(p, N_PAIRS)]),
      .hi_i     (pwm_hi_i[p]),
      .lo_i     (pwm_lo_i[p]),
      .hi_o     (hi_d[p]),
      .lo_o     (lo_d[p])
    );
  end

  pwm_oc_pad_reg #(.N(N_PAIRS)) pad_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hi_i   (hi_d),
    .lo_i   (lo_d),
    .hi_o   (pad_hi_o),
    .lo_o   (pad_lo_o)
  );
endmodule

// File: rtl/pwm_out_ctrl_chk.sv
module pwm_out_ctrl_chk #(
  parameter int N_PAIRS = 3,
  localparam int CW = 3 * N_PAIRS
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_wr_i,
  input logic [CW-1:0]      cfg_wdata_i,
  input logic [CW-1:0]      cfg_rdata_o,
  input logic               period_start_i,
  input logic [N_PAIRS-1:0] pwm_hi_i,
  input logic [N_PAIRS-1:0] pwm_lo_i,
  input logic [N_PAIRS-1:0] pad_hi_o,
  input logic [N_PAIRS-1:0] pad_lo_o,
  input logic [CW-1:0]      act_cfg
);
  import pwm_oc_pkg::*;

  logic primed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  // R2
  rdata_follows_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> cfg_rdata_o == $past(cfg_wdata_i));

  // R3
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_start_i |=> $stable(act_cfg));

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_chk
    localparam int XB = xover_bit(p, N_PAIRS);
    localparam int DH = dis_hi_bit(p, N_PAIRS);
    localparam int DL = dis_lo_bit(p, N_PAIRS);

    // R6
    hi_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_cfg[DH] |-> !pad_hi_o[p]);
    // R6
    lo_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_cfg[DL] |-> !pad_lo_o[p]);
    // R7
    hi_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (primed && !act_cfg[XB] && !act_cfg[DH]) |-> pad_hi_o[p] == $past(pwm_hi_i[p]));
    // R5
    hi_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (primed && act_cfg[XB] && !act_cfg[DH]) |-> pad_hi_o[p] == $past(pwm_lo_i[p]));
    // R5
    lo_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (primed && act_cfg[XB] && !act_cfg[DL]) |-> pad_lo_o[p] == $past(pwm_hi_i[p]));
  end
endmodule

bind pwm_out_ctrl pwm_out_ctrl_chk #(.N_PAIRS(N_PAIRS)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_wr_i       (cfg_wr_i),
  .cfg_wdata_i    (cfg_wdata_i),
  .cfg_rdata_o    (cfg_rdata_o),
  .period_start_i (period_start_i),
  .pwm_hi_i       (pwm_hi_i),
  .pwm_lo_i       (pwm_lo_i),
  .pad_hi_o       (pad_hi_o),
  .pad_lo_o       (pad_lo_o),
  .act_cfg        (act_cfg)
);

// File: tb/pwm_out_ctrl_tb_top.sv
module pwm_out_ctrl_tb_top;
  localparam int NP = 3;
  localparam int CW = 3 * NP;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_wr_i = 1'b0;
  logic [CW-1:0] cfg_wdata_i = '0;
  logic [CW-1:0] cfg_rdata_o;
  logic          period_start_i = 1'b0;
  logic [NP-1:0] pwm_hi_i = '0, pwm_lo_i = '0;
  logic [NP-1:0] pad_hi_o, pad_lo_o;

  always #10 clk_i = ~clk_i;

  pwm_out_ctrl #(.N_PAIRS(NP)) dut_i (.*);

  typedef struct {
    int            due;
    logic [NP-1:0] hi;
    logic [NP-1:0] lo;
    logic [CW-1:0] rd;
    string         req;
  } exp_t;

  exp_t sb[$];
  int cyc = 0;
  int total = 0, bad = 0;
  logic [CW-1:0] m_pend = '0, m_act = '0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: compare entries due at the current rising-edge count
  always @(negedge clk_i) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      check({pad_hi_o, pad_lo_o, cfg_rdata_o} == {e.hi, e.lo, e.rd}, e.req,
            "pads/rdata", {17'd0, pad_hi_o, pad_lo_o, cfg_rdata_o},
            {17'd0, e.hi, e.lo, e.rd});
    end
  end

  // driver: apply inputs and push the expected result from the requirements
  task automatic step(input logic wr, input logic [CW-1:0] wd, input logic ps,
                      input logic [NP-1:0] hi, input logic [NP-1:0] lo, input string req);
    exp_t e;
    logic [CW-1:0] eff;
    @(negedge clk_i);
    cfg_wr_i = wr; cfg_wdata_i = wd; period_start_i = ps;
    pwm_hi_i = hi; pwm_lo_i = lo;
    eff = ps ? (wr ? wd : m_pend) : m_act;            // R4 R8
    for (int p = 0; p < NP; p++) begin
      logic x;
      x = eff[3*NP-1-p];                               // R5
      e.hi[p] = (x ? lo[p] : hi[p]) & ~eff[2*NP-1-2*p]; // R6
      e.lo[p] = (x ? hi[p] : lo[p]) & ~eff[2*NP-2-2*p];
    end
    if (wr) m_pend = wd;
    if (ps) m_act = eff;
    e.rd = m_pend;                                     // R2
    e.due = cyc + 1;                                   // R7
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0, '0, "R7");
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    cfg_wr_i = 1'b0; period_start_i = 1'b0;
    pwm_hi_i = '1; pwm_lo_i = '1;
    sb.delete();
    m_pend = '0; m_act = '0;
    #2;
    check(cfg_rdata_o == '0, "R1", "rdata in reset", {23'd0, cfg_rdata_o}, 32'd0);
    check(pad_hi_o == '0 && pad_lo_o == '0, "R1", "pads in reset",
          {26'd0, pad_hi_o, pad_lo_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    do_reset();
    // R1: pass-through after reset
    for (int v = 0; v < 64; v++) step(1'b0, '0, 1'b0, v[5:3], v[2:0], "R1");
    // R2 R3: pending write, pads unchanged
    step(1'b1, 9'h100, 1'b0, 3'b001, 3'b000, "R3");
    for (int v = 0; v < 8; v++) step(1'b0, '0, 1'b0, v[2:0], ~v[2:0], "R3");
    // R4: apply at period start
    step(1'b0, '0, 1'b1, 3'b001, 3'b000, "R4");
    // R5: each pair crossed
    for (int v = 0; v < 16; v++) step(1'b0, '0, 1'b0, v[3:1], v[2:0], "R5");
    step(1'b1, 9'h080, 1'b1, 3'b010, 3'b000, "R5");
    for (int v = 0; v < 8; v++) step(1'b0, '0, 1'b0, v[2:0], ~v[2:0], "R5");
    step(1'b1, 9'h040, 1'b0, 3'b100, 3'b000, "R3");
    step(1'b0, '0, 1'b1, 3'b100, 3'b011, "R5");
    step(1'b1, 9'h1C0, 1'b1, 3'b101, 3'b010, "R5");
    // R6: disables per physical pad, after swap
    step(1'b1, 9'h03F, 1'b1, 3'b111, 3'b111, "R6");
    for (int b = 0; b < 6; b++) begin
      step(1'b1, 9'(1 << b), 1'b1, 3'b111, 3'b111, "R6");
      step(1'b1, 9'h1C0 | 9'(1 << b), 1'b1, 3'b111, 3'b111, "R6");
      step(1'b1, 9'h1C0 | 9'(1 << b), 1'b1, 3'b000, 3'b111, "R6");
    end
    // R8: coincident write and period start
    step(1'b1, 9'h100, 1'b0, 3'b111, 3'b000, "R2");
    step(1'b1, 9'h020, 1'b1, 3'b001, 3'b001, "R8");
    step(1'b0, '0, 1'b0, 3'b001, 3'b001, "R8");
    // mixed traffic
    for (int i = 0; i < 400; i++)
      step(($urandom % 4) == 0, 9'($urandom), ($urandom % 5) == 0,
           3'($urandom), 3'($urandom), "R4");
    idle(2);
    // R1: reset clears non-zero configuration
    step(1'b1, 9'h1FF, 1'b1, '1, '1, "R6");
    idle(2);
    do_reset();
    for (int v = 0; v < 8; v++) step(1'b0, '0, 1'b0, v[2:0], v[2:0] ^ 3'b101, "R1");
    idle(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4000000;
    total++; bad++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule